// File: doc/BRIEF.md
# Software-Filled Paired-Page Translation Buffer

This block is a small fully associative translation buffer that turns 32-bit virtual addresses into physical addresses for 4 KB pages. Each of its 16 entries covers two neighbouring virtual pages. The entry holds one tag for the pair and two frame descriptors. Bit 12 of the virtual address picks between them: a clear bit selects the even frame and a set bit selects the odd frame. Each frame descriptor carries a frame number, a 3-bit cache attribute, a dirty bit and a valid bit.

The block never reads memory. Operating-system software fills it through a write port. That port either targets an explicit slot or lets a replacement counter pick the slot. The counter always skips the slots below a programmable wired limit. Each lookup is answered one clock later with one of four outcomes: a hit, a miss, an invalid-page fault or a modify fault. The hit outcome comes with the translated address and the frame's attribute and dirty bit.

Top module: `soft_tlb`

## Requirements
- R1: After reset every slot is empty, rs_valid is low, and any lookup reports a miss.
- R2: A lookup presented with lk_valid high at a clock edge is answered at the next edge. rs_valid is high for exactly that one cycle per lookup.
- R3: On a hit, rs_paddr is the selected frame number (bits 31:12) joined with lk_vaddr[11:0]. rs_cattr and rs_dirty come from that frame. lk_vaddr[12]=0 selects the even frame and lk_vaddr[12]=1 selects the odd frame.
- R4: When no occupied slot has a tag equal to lk_vaddr[31:13], the outcome is miss (code 1).
- R5: When the tag matches but the selected frame's valid bit is clear, the outcome is invalid (code 2). A hit is code 0.
- R6: A store (lk_store=1) to a valid frame whose dirty bit is clear gives modify (code 3). A load to the same frame gives a hit, and a store to a dirty frame gives a hit.
- R7: For every outcome other than hit, rs_paddr, rs_cattr and rs_dirty are all zero.
- R8: An indexed write (wr_random=0) replaces slot wr_index completely, including its tag.
- R9: A replacement pointer resets to 0. A random write (wr_random=1) uses the pointer's slot, or the wired limit if the pointer is below that limit. The pointer then moves to the next slot, and wraps from 15 back to the wired limit.
- R10: Slots below the wired limit (set through wired_we/wired_val, reset value 0) are never chosen by a random write.
- R11: A write whose tag equals the tag of another occupied slot empties that other slot, so at most one slot matches any address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_valid | input | 1 | Lookup request |
| lk_vaddr | input | 32 | Virtual address to translate |
| lk_store | input | 1 | Lookup is for a store |
| rs_valid | output | 1 | Lookup result present |
| rs_outcome | output | 2 | 0 hit, 1 miss, 2 invalid, 3 modify |
| rs_paddr | output | 32 | Translated physical address |
| rs_cattr | output | 3 | Cache attribute of the selected frame |
| rs_dirty | output | 1 | Dirty bit of the selected frame |
| wr_en | input | 1 | Write one slot |
| wr_random | input | 1 | Slot is chosen by the replacement pointer |
| wr_index | input | 4 | Slot for an indexed write |
| wr_pair_tag | input | 19 | Virtual page-pair tag (vaddr bits 31:13) |
| wr_even_pfn | input | 20 | Even frame number |
| wr_even_cattr | input | 3 | Even frame cache attribute |
| wr_even_dirty | input | 1 | Even frame dirty bit |
| wr_even_valid | input | 1 | Even frame valid bit |
| wr_odd_pfn | input | 20 | Odd frame number |
| wr_odd_cattr | input | 3 | Odd frame cache attribute |
| wr_odd_dirty | input | 1 | Odd frame dirty bit |
| wr_odd_valid | input | 1 | Odd frame valid bit |
| wired_we | input | 1 | Load the wired limit |
| wired_val | input | 4 | New wired limit |

## Verification
A corrupted slot shows up at the first lookup of its pair. Depending on which bits are wrong, the result is a wrong frame number, a wrong attribute or a wrong fault code, and it appears one cycle after the request. A stale duplicate is different: it appears only when the replaced tag is looked up again. It then gives a hit on the old frame where a miss or the new frame was due. A replacement pointer that drifts stays hidden until a later lookup finds a slot that should have survived, or a pair that should have been evicted. The bench therefore follows every write with lookups of both the new tag and the displaced tags.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
  typedef enum logic [1:0] {
    OC_HIT     = 2'd0,
    OC_MISS    = 2'd1,
    OC_INVALID = 2'd2,
    OC_MODIFY  = 2'd3
  } outcome_e;
endpackage

// File: rtl/tlb_cam.sv
module tlb_cam #(
  parameter int ENTRIES = 16,
  parameter int TAG_W   = 19,
  parameter int FRM_W   = 25,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_slot,
  input  logic [TAG_W-1:0] wr_tag,
  input  logic [FRM_W-1:0] wr_even,
  input  logic [FRM_W-1:0] wr_odd,
  input  logic [TAG_W-1:0] lk_tag,
  output logic             hit_any,
  output logic [FRM_W-1:0] sel_even,
  output logic [FRM_W-1:0] sel_odd
);
  logic [ENTRIES-1:0] match_vec;
  logic [ENTRIES-1:0] kill_vec;
  logic [FRM_W-1:0]   even_arr [ENTRIES];
  logic [FRM_W-1:0]   odd_arr  [ENTRIES];

  for (genvar g = 0; g < ENTRIES; g++) begin : g_slot
    logic             used_q;
    logic [TAG_W-1:0] tag_q;
    logic [FRM_W-1:0] even_q, odd_q;
    logic             take;

    assign take        = wr_en && (wr_slot == IDX_W'(g));
    assign kill_vec[g] = wr_en && !take && used_q && (tag_q == wr_tag);
    assign match_vec[g] = used_q && (tag_q == lk_tag);
    assign even_arr[g] = even_q;
    assign odd_arr[g]  = odd_q;

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        used_q <= 1'b0;
        tag_q  <= '0;
        even_q <= '0;
        odd_q  <= '0;
      end else if (take) begin
        used_q <= 1'b1;
        tag_q  <= wr_tag;
        even_q <= wr_even;
        odd_q  <= wr_odd;
      end else if (kill_vec[g]) begin
        used_q <= 1'b0;
      end
    end
  end

  always_comb begin
    hit_any  = |match_vec;
    sel_even = '0;
    sel_odd  = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (match_vec[i]) begin
        sel_even = sel_even | even_arr[i];
        sel_odd  = sel_odd  | odd_arr[i];
      end
    end
  end

  // R11
  one_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(match_vec));

  // R11
  kill_only_other_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(kill_vec) <= 1);
endmodule

// File: rtl/tlb_victim.sv
module tlb_victim #(
  parameter int ENTRIES = 16,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wired_we,
  input  logic [IDX_W-1:0] wired_val,
  input  logic             rnd_we,
  output logic [IDX_W-1:0] victim
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(ENTRIES - 1);

  logic [IDX_W-1:0] ptr_q;
  logic [IDX_W-1:0] wired_q;

  function automatic logic [IDX_W-1:0] clamp_slot(
    input logic [IDX_W-1:0] p, input logic [IDX_W-1:0] floor_v);
    return (p < floor_v) ? floor_v : p;
  endfunction

  function automatic logic [IDX_W-1:0] step_slot(
    input logic [IDX_W-1:0] used_slot, input logic [IDX_W-1:0] floor_v);
    return (used_slot == LAST) ? floor_v : used_slot + 1'b1;
  endfunction

  assign victim = clamp_slot(ptr_q, wired_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ptr_q   <= '0;
      wired_q <= '0;
    end else begin
      if (rnd_we)   ptr_q   <= step_slot(victim, wired_q);
      if (wired_we) wired_q <= wired_val;
    end
  end

  // R10
  victim_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rnd_we |-> victim >= wired_q);

  // R9
  ptr_moves_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rnd_we && !wired_we) |=> ptr_q != $past(victim) || wired_q == LAST);
endmodule

// File: rtl/tlb_resolve.sv
module tlb_resolve #(
  parameter int PFN_W   = 20,
  parameter int CATTR_W = 3,
  parameter int PG_W    = 12,
  localparam int FRM_W  = PFN_W + CATTR_W + 2,
  localparam int PA_W   = PFN_W + PG_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               lk_valid,
  input  logic               lk_store,
  input  logic               lk_odd,
  input  logic [PG_W-1:0]    lk_offset,
  input  logic               hit_any,
  input  logic [FRM_W-1:0]   sel_even,
  input  logic [FRM_W-1:0]   sel_odd,
  output logic               rs_valid,
  output tlb_pkg::outcome_e  rs_outcome,
  output logic [PA_W-1:0]    rs_paddr,
  output logic [CATTR_W-1:0] rs_cattr,
  output logic               rs_dirty
);
  import tlb_pkg::*;

  function automatic outcome_e classify(input logic hit, input logic valid,
                                        input logic dirty, input logic store);
    if (!hit)            return OC_MISS;
    if (!valid)          return OC_INVALID;
    if (store && !dirty) return OC_MODIFY;
    return OC_HIT;
  endfunction

  function automatic logic [PA_W-1:0] join_addr(input logic [PFN_W-1:0] pfn,
                                                input logic [PG_W-1:0] off);
    return {pfn, off};
  endfunction

  logic [FRM_W-1:0]   frame;
  logic [PFN_W-1:0]   f_pfn;
  logic [CATTR_W-1:0] f_cattr;
  logic               f_dirty, f_valid;
  outcome_e           oc;

  assign frame   = lk_odd ? sel_odd : sel_even;
  assign f_pfn   = frame[PFN_W-1:0];
  assign f_cattr = frame[PFN_W +: CATTR_W];
  assign f_dirty = frame[PFN_W + CATTR_W];
  assign f_valid = frame[FRM_W-1];
  assign oc      = classify(hit_any, f_valid, f_dirty, lk_store);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rs_valid   <= 1'b0;
      rs_outcome <= OC_MISS;
      rs_paddr   <= '0;
      rs_cattr   <= '0;
      rs_dirty   <= 1'b0;
    end else begin
      rs_valid <= lk_valid;
      if (lk_valid) begin
        rs_outcome <= oc;
        rs_paddr   <= (oc == OC_HIT) ? join_addr(f_pfn, lk_offset) : '0;
        rs_cattr   <= (oc == OC_HIT) ? f_cattr : '0;
        rs_dirty   <= (oc == OC_HIT) ? f_dirty : 1'b0;
      end
    end
  end

  // R2
  lat_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lk_valid |=> rs_valid);

  // R2
  lat_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_valid |=> !rs_valid);

  // R7
  miss_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rs_valid && rs_outcome != OC_HIT) |-> (rs_paddr == '0 && rs_cattr == '0 && !rs_dirty));

  // R3
  hit_offset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lk_valid |=> (rs_outcome != OC_HIT || rs_paddr[PG_W-1:0] == $past(lk_offset)));

  // R4
  miss_needs_nomatch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_valid && !hit_any) |=> rs_outcome == OC_MISS);
endmodule

// File: rtl/soft_tlb.sv
module soft_tlb #(
  parameter int VA_W    = 32,
  parameter int PA_W    = 32,
  parameter int PG_W    = 12,
  parameter int CATTR_W = 3,
  parameter int ENTRIES = 16,
  localparam int TAG_W  = VA_W - PG_W - 1,
  localparam int PFN_W  = PA_W - PG_W,
  localparam int IDX_W  = $clog2(ENTRIES),
  localparam int FRM_W  = PFN_W + CATTR_W + 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               lk_valid,
  input  logic [VA_W-1:0]    lk_vaddr,
  input  logic               lk_store,
  output logic               rs_valid,
  output logic [1:0]         rs_outcome,
  output logic [PA_W-1:0]    rs_paddr,
  output logic [CATTR_W-1:0] rs_cattr,
  output logic               rs_dirty,
  input  logic               wr_en,
  input  logic               wr_random,
  input  logic [IDX_W-1:0]   wr_index,
  input  logic [TAG_W-1:0]   wr_pair_tag,
  input  logic [PFN_W-1:0]   wr_even_pfn,
  input  logic [CATTR_W-1:0] wr_even_cattr,
  input  logic               wr_even_dirty,
  input  logic               wr_even_valid,
  input  logic [PFN_W-1:0]   wr_odd_pfn,
  input  logic [CATTR_W-1:0] wr_odd_cattr,
  input  logic               wr_odd_dirty,
  input  logic               wr_odd_valid,
  input  logic               wired_we,
  input  logic [IDX_W-1:0]   wired_val
);
  function automatic logic [FRM_W-1:0] pack_frame(
    input logic [PFN_W-1:0] pfn, input logic [CATTR_W-1:0] ca,
    input logic d, input logic v);
    return {v, d, ca, pfn};
  endfunction

  logic [IDX_W-1:0] victim, wr_slot;
  logic             hit_any;
  logic [FRM_W-1:0] sel_even, sel_odd;
  tlb_pkg::outcome_e oc;

  assign wr_slot = wr_random ? victim : wr_index;

  tlb_victim #(.ENTRIES(ENTRIES)) u_victim (
    .clk(clk), .rst_n(rst_n), .wired_we(wired_we), .wired_val(wired_val),
    .rnd_we(wr_en && wr_random), .victim(victim));

  tlb_cam #(.ENTRIES(ENTRIES), .TAG_W(TAG_W), .FRM_W(FRM_W)) u_cam (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_slot(wr_slot),
    .wr_tag(wr_pair_tag),
    .wr_even(pack_frame(wr_even_pfn, wr_even_cattr, wr_even_dirty, wr_even_valid)),
    .wr_odd(pack_frame(wr_odd_pfn, wr_odd_cattr, wr_odd_dirty, wr_odd_valid)),
    .lk_tag(lk_vaddr[VA_W-1:PG_W+1]),
    .hit_any(hit_any), .sel_even(sel_even), .sel_odd(sel_odd));

  tlb_resolve #(.PFN_W(PFN_W), .CATTR_W(CATTR_W), .PG_W(PG_W)) u_resolve (
    .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_store(lk_store),
    .lk_odd(lk_vaddr[PG_W]), .lk_offset(lk_vaddr[PG_W-1:0]),
    .hit_any(hit_any), .sel_even(sel_even), .sel_odd(sel_odd),
    .rs_valid(rs_valid), .rs_outcome(oc), .rs_paddr(rs_paddr),
    .rs_cattr(rs_cattr), .rs_dirty(rs_dirty));

  assign rs_outcome = oc;
endmodule

// File: tb/soft_tlb_bench.sv
module soft_tlb_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic lk_valid = 0, lk_store = 0;
  logic [31:0] lk_vaddr = '0;
  logic rs_valid, rs_dirty;
  logic [1:0] rs_outcome;
  logic [31:0] rs_paddr;
  logic [2:0] rs_cattr;
  logic wr_en = 0, wr_random = 0;
  logic [3:0] wr_index = '0;
  logic [18:0] wr_pair_tag = '0;
  logic [19:0] wr_even_pfn = '0, wr_odd_pfn = '0;
  logic [2:0] wr_even_cattr = '0, wr_odd_cattr = '0;
  logic wr_even_dirty = 0, wr_even_valid = 0, wr_odd_dirty = 0, wr_odd_valid = 0;
  logic wired_we = 0;
  logic [3:0] wired_val = '0;

  int checks = 0, fails = 0;
  bit done = 0;

  always #4 clk = ~clk;

  soft_tlb u_soft_tlb (.*);

  // reference model
  bit          m_used [16];
  logic [18:0] m_tag  [16];
  logic [19:0] m_pfn  [16][2];
  logic [2:0]  m_ca   [16][2];
  bit          m_d    [16][2];
  bit          m_v    [16][2];
  int          m_ptr = 0, m_wired = 0;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_write(input bit rnd, input int idx, input logic [18:0] tag,
                          input logic [19:0] p0, input logic [2:0] c0, input bit d0, input bit v0,
                          input logic [19:0] p1, input logic [2:0] c1, input bit d1, input bit v1);
    int tgt;
    @(negedge clk);
    wr_en = 1; wr_random = rnd; wr_index = 4'(idx); wr_pair_tag = tag;
    wr_even_pfn = p0; wr_even_cattr = c0; wr_even_dirty = d0; wr_even_valid = v0;
    wr_odd_pfn = p1; wr_odd_cattr = c1; wr_odd_dirty = d1; wr_odd_valid = v1;
    if (rnd) begin
      tgt = (m_ptr < m_wired) ? m_wired : m_ptr;
      m_ptr = (tgt == 15) ? m_wired : tgt + 1;
    end else tgt = idx;
    for (int j = 0; j < 16; j++)
      if (j != tgt && m_used[j] && m_tag[j] == tag) m_used[j] = 0;
    m_used[tgt] = 1; m_tag[tgt] = tag;
    m_pfn[tgt][0] = p0; m_ca[tgt][0] = c0; m_d[tgt][0] = d0; m_v[tgt][0] = v0;
    m_pfn[tgt][1] = p1; m_ca[tgt][1] = c1; m_d[tgt][1] = d1; m_v[tgt][1] = v1;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic set_wired(input int w);
    @(negedge clk);
    wired_we = 1; wired_val = 4'(w); m_wired = w;
    @(negedge clk);
    wired_we = 0;
  endtask

  // expected result from the requirements
  task automatic expect_of(input logic [31:0] va, input bit st, output int oc,
                           output logic [31:0] pa, output logic [2:0] ca, output bit d);
    int hit = -1;
    int h = va[12];
    for (int j = 0; j < 16; j++) if (m_used[j] && m_tag[j] == va[31:13]) hit = j;
    oc = 1; pa = 0; ca = 0; d = 0;
    if (hit >= 0) begin
      if (!m_v[hit][h]) oc = 2;
      else if (st && !m_d[hit][h]) oc = 3;
      else begin
        oc = 0; pa = {m_pfn[hit][h], va[11:0]}; ca = m_ca[hit][h]; d = m_d[hit][h];
      end
    end
  endtask

  task automatic look(input logic [31:0] va, input bit st, input string req);
    int oc; logic [31:0] pa; logic [2:0] ca; bit d;
    expect_of(va, st, oc, pa, ca, d);
    @(negedge clk);
    lk_valid = 1; lk_vaddr = va; lk_store = st;
    @(negedge clk);
    lk_valid = 0;
    chk(rs_valid == 1'b1, {req, "/R2 valid"}, rs_valid, 1);
    chk(rs_outcome == 2'(oc), {req, " outcome"}, rs_outcome, oc);
    chk(rs_paddr == pa, {req, "/R7 paddr"}, rs_paddr, pa);
    chk(rs_cattr == ca && rs_dirty == d, {req, "/R7 attr"}, {rs_cattr, rs_dirty}, {ca, d});
    @(negedge clk);
    chk(rs_valid == 1'b0, "R2 single-cycle valid", rs_valid, 0);
  endtask

  function automatic string req_of(input int oc);
    case (oc) 0: return "R3"; 1: return "R4"; 2: return "R5"; default: return "R6"; endcase
  endfunction

  initial begin
    void'($urandom(32'd7741));
    for (int j = 0; j < 16; j++) m_used[j] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1
    chk(rs_valid == 1'b0, "R1 rs_valid after reset", rs_valid, 0);
    look(32'h1234_5678, 0, "R1");
    look(32'h0000_0000, 1, "R1");

    // R3 R6: both halves, loads and stores
    do_write(0, 3, 19'h0AAAA, 20'hABCDE, 3'd5, 1, 1, 20'h13579, 3'd2, 0, 1);
    look({19'h0AAAA, 1'b0, 12'h3C4}, 0, "R3 even");
    look({19'h0AAAA, 1'b1, 12'hFFF}, 0, "R3 odd");
    look({19'h0AAAA, 1'b1, 12'h001}, 1, "R6 store clean");
    look({19'h0AAAA, 1'b0, 12'h800}, 1, "R6 store dirty");
    look({19'h0AAAB, 1'b0, 12'h800}, 0, "R4 R7");

    // R5
    do_write(0, 4, 19'h01111, 20'h22222, 3'd1, 1, 1, 20'h33333, 3'd3, 1, 0);
    look({19'h01111, 1'b1, 12'h010}, 0, "R5 odd invalid");
    look({19'h01111, 1'b0, 12'h010}, 1, "R5 even ok");

    // R8
    do_write(0, 3, 19'h05555, 20'h44444, 3'd6, 1, 1, 20'h55555, 3'd7, 1, 1);
    look({19'h0AAAA, 1'b0, 12'h000}, 0, "R8 old tag gone");
    look({19'h05555, 1'b1, 12'h0AB}, 0, "R8 new tag");

    // R11
    do_write(0, 5, 19'h01111, 20'h66666, 3'd4, 1, 1, 20'h77777, 3'd4, 1, 1);
    look({19'h01111, 1'b1, 12'h123}, 0, "R11 duplicate replaced");
    do_write(0, 5, 19'h03333, 20'h88888, 3'd0, 0, 1, 20'h99999, 3'd0, 0, 1);
    look({19'h01111, 1'b0, 12'h123}, 0, "R11 older copy cleared");

    // R9: pointer starts at 0
    do_write(1, 0, 19'h04444, 20'h0F0F0, 3'd2, 1, 1, 20'h0E0E0, 3'd2, 1, 1);
    look({19'h04444, 1'b0, 12'h456}, 0, "R9 random write");
    do_write(0, 0, 19'h06666, 20'h0D0D0, 3'd1, 1, 1, 20'h0C0C0, 3'd1, 1, 1);
    look({19'h04444, 1'b0, 12'h456}, 0, "R9 landed in slot 0");

    // R10
    set_wired(8);
    for (int i = 0; i < 8; i++)
      do_write(0, i, 19'h10000 + 19'(i), 20'(i * 4099), 3'(i), 1, 1, 20'(i * 77), 3'(i), 1, 1);
    for (int i = 0; i < 20; i++)
      do_write(1, 0, 19'h20000 + 19'(i), 20'(i), 3'd1, 1, 1, 20'(i + 1), 3'd1, 1, 1);
    for (int i = 0; i < 8; i++)
      look({19'h10000 + 19'(i), 1'(i), 12'(i * 37)}, 0, "R10 wired slot kept");
    look({19'h20000 + 19'd19, 1'b0, 12'h0}, 0, "R9 last random kept");
    look({19'h20000 + 19'd3, 1'b0, 12'h0}, 0, "R9 early random evicted");

    // constrained random
    for (int n = 0; n < 600; n++) begin
      int op = $urandom_range(0, 9);
      logic [18:0] tg = 19'h30000 + 19'($urandom_range(0, 9));
      if (op < 2)
        do_write(0, $urandom_range(0, 15), tg, 20'($urandom), 3'($urandom), 1'($urandom),
                 1'($urandom_range(0, 3) != 0), 20'($urandom), 3'($urandom), 1'($urandom),
                 1'($urandom_range(0, 3) != 0));
      else if (op < 4)
        do_write(1, 0, tg, 20'($urandom), 3'($urandom), 1'($urandom), 1'b1,
                 20'($urandom), 3'($urandom), 1'($urandom), 1'($urandom));
      else if (op == 4 && $urandom_range(0, 7) == 0)
        set_wired($urandom_range(0, 12));
      else begin
        int oc; logic [31:0] pa; logic [2:0] ca; bit d;
        logic [31:0] va = {tg, 13'($urandom)};
        bit st = 1'($urandom);
        expect_of(va, st, oc, pa, ca, d);
        look(va, st, req_of(oc));
      end
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule